// File: doc/BRIEF.md
# Audio Codec Serial Host Controller

This block is the host end of a serial link to an audio codec that behaves as an SPI slave. Two logical channels share one clock line and one pair of data lines. A register channel carries 32-bit frames (an opcode byte, an address byte and a 16-bit word). A stream channel carries audio bytes. Each channel has its own active-low select. The codec drives a request line, and no frame of either kind starts unless that line is high.

Register reads and writes come in on a valid/ready command port. Read results leave on a data output with a one-cycle strobe. Audio bytes come in on a valid/ready byte port and are grouped into bursts of at most 32 bytes per data-select frame. Pending register commands win over audio, but only at a byte boundary. The serial clock is derived from the system clock with a programmable half-period. The order of audio bits is selectable. After every register write, a programmable number of system cycles must pass before the next frame starts, so that the codec has time to settle.

Top module: `codec_spi_host`

## Requirements
- R1: A register frame is 32 bits sent MSB-first on `ctl_cs_n`: opcode 0x02 (write) or 0x03 (read), then the 8-bit address, then the 16-bit word. A read sends sixteen zero bits in place of the word.
- R2: During a read, the MISO bits sampled at the last 16 rising edges form `rd_data` MSB-first. `rd_valid` pulses for one cycle in the cycle where `ctl_cs_n` returns high, and at no other time.
- R3: Audio bytes go out on `dat_cs_n` in the order they were accepted. With `cfg_lsb_first`=1 bit 0 is sent first; with 0, bit 7 is sent first.
- R4: `ctl_cs_n` and `dat_cs_n` are never low at the same time.
- R5: A select falls only in the cycle after `dreq` was sampled high. While `dreq` is low, no frame starts and requests stay pending.
- R6: An audio frame holds at most 32 bytes. Inside a frame, the next byte follows without releasing the select only while `dreq` is high and a byte is waiting. After 32 bytes the select is released and `dreq` is checked again.
- R7: SPI mode 0 is used. SCLK is low whenever both selects are high, MOSI changes on falling edges and MISO is sampled on rising edges. Each SCLK half-period lasts `cfg_half_div` system cycles, and a value of 0 acts as 1.
- R8: The first rising SCLK edge comes one half-period after the select falls. The select rises one half-period after the last falling edge. It then stays high for at least one half-period.
- R9: After a register write, the next select falls no sooner than half-period + `cfg_wait` + 1 cycles after `ctl_cs_n` rises. It falls exactly then when a request is already waiting.
- R10: A command that becomes pending during an audio frame ends that frame at the next byte boundary. The register frame is sent before any further audio.
- R11: After reset both selects are high, SCLK is low and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half_div | input | 8 | SCLK half-period in system cycles (0 acts as 1) |
| cfg_lsb_first | input | 1 | Audio bit order: 1 sends bit 0 first |
| cfg_wait | input | 16 | Settling cycles enforced after each register write |
| cmd_valid | input | 1 | Register command offered |
| cmd_ready | output | 1 | Register command taken this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 16 | Write word |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 16 | Read result |
| aud_valid | input | 1 | Audio byte offered |
| aud_ready | output | 1 | Audio byte taken this cycle |
| aud_data | input | 8 | Audio byte |
| dreq | input | 1 | Codec ready for traffic |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to codec |
| miso | input | 1 | Serial data from codec |
| ctl_cs_n | output | 1 | Register-channel select, active low |
| dat_cs_n | output | 1 | Audio-channel select, active low |

## Verification
The register path gets writes and reads mixed at random. Each read answers with an address-dependent word, so a wrong opcode, a misplaced address or a shifted capture shows up as a data mismatch. Audio bytes are streamed at several divider values, including 0, and with both bit orders. This separates a wrong half-period or a wrong bit order from a correct stream. Directed runs cover the rest. A long stream checks the 32-byte burst split. A command injected mid-burst checks that the frame ends on a byte boundary and that the register frame goes first. Holding `dreq` low must block any start. Back-to-back writes measure the settling gap to the exact cycle.

// File: rtl/codec_spi_pkg.sv
package codec_spi_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_LOW,
        PH_HOLD,
        PH_GAP,
        PH_WAIT
    } phase_e;

    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam int         BYTE_BITS = 8;

    function automatic logic [7:0] swap_bits8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            r[i] = v[7-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/codec_spi_tick.sv
module codec_spi_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_state_t;

    tick_state_t s_q, s_d;
    logic [DIV_W-1:0] span;

    always_comb begin
        span = (half_div == '0) ? DIV_W'(1) : half_div;
        tick = en && (s_q.cnt == span - DIV_W'(1));
        s_d  = s_q;
        if (!en || tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7: the counter never runs past the programmed half-period
    assert_tick_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (s_q.cnt < span));

endmodule

// File: rtl/codec_spi_shreg.sv
module codec_spi_shreg #(
    parameter int TX_W = 32,
    parameter int RX_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_val,
    input  logic            shift,
    input  logic            sample,
    input  logic            miso,
    output logic            mosi,
    output logic [RX_W-1:0] rx_word
);
    typedef struct packed {
        logic [TX_W-1:0] tx;
        logic [RX_W-1:0] rx;
    } sr_state_t;

    sr_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.tx = load_val;
        end else if (shift) begin
            s_d.tx = {s_q.tx[TX_W-2:0], 1'b0};
        end
        if (sample) begin
            s_d.rx = {s_q.rx[RX_W-2:0], miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mosi    = s_q.tx[TX_W-1];
    assign rx_word = s_q.rx;

    // R7: new data is loaded and shifted only on separate falling-edge events
    assert_load_shift_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/codec_spi_host.sv
module codec_spi_host #(
    parameter int DIV_W  = 8,
    parameter int WAIT_W = 16,
    parameter int BURST  = 32,
    parameter int ADDR_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic              cfg_lsb_first,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    input  logic              aud_valid,
    output logic              aud_ready,
    input  logic [7:0]        aud_data,
    input  logic              dreq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              ctl_cs_n,
    output logic              dat_cs_n
);
    import codec_spi_pkg::*;

    localparam int CTL_BITS = 8 + ADDR_W + WORD_W;
    localparam int BIT_W    = $clog2(CTL_BITS);
    localparam int BYTE_W   = $clog2(BURST + 1);
    localparam logic [BIT_W-1:0]  CTL_LAST = BIT_W'(CTL_BITS - 1);
    localparam logic [BIT_W-1:0]  AUD_LAST = BIT_W'(BYTE_BITS - 1);
    localparam logic [BYTE_W-1:0] BURST_N  = BYTE_W'(BURST);

    typedef struct packed {
        phase_e              ph;
        logic                sclk;
        logic                ctl_cs_n;
        logic                dat_cs_n;
        logic [BIT_W-1:0]    bit_cnt;
        logic [BYTE_W-1:0]   byte_cnt;
        logic                is_ctl;
        logic                is_rd;
        logic [WAIT_W-1:0]   wait_cnt;
        logic [WORD_W-1:0]   rd_data;
        logic                rd_valid;
    } host_state_t;

    host_state_t s_q, s_d;

    logic                tick;
    logic                clk_en;
    logic                load;
    logic [CTL_BITS-1:0] load_val;
    logic                shift;
    logic                sample;
    logic [WORD_W-1:0]   rx_word;
    logic [BIT_W-1:0]    last_bit;
    logic [7:0]          aud_ordered;

    assign clk_en      = (s_q.ph != PH_IDLE) && (s_q.ph != PH_WAIT);
    assign last_bit    = s_q.is_ctl ? CTL_LAST : AUD_LAST;
    assign aud_ordered = cfg_lsb_first ? swap_bits8(aud_data) : aud_data;

    codec_spi_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (clk_en),
        .half_div (cfg_half_div),
        .tick     (tick)
    );

    codec_spi_shreg #(.TX_W(CTL_BITS), .RX_W(WORD_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .shift    (shift),
        .sample   (sample),
        .miso     (miso),
        .mosi     (mosi),
        .rx_word  (rx_word)
    );

    always_comb begin
        s_d          = s_q;
        s_d.rd_valid = 1'b0;
        load         = 1'b0;
        load_val     = '0;
        shift        = 1'b0;
        sample       = 1'b0;
        cmd_ready    = 1'b0;
        aud_ready    = 1'b0;

        case (s_q.ph)
            PH_IDLE: begin
                if (dreq && cmd_valid) begin
                    cmd_ready    = 1'b1;
                    load         = 1'b1;
                    load_val     = {(cmd_write ? OPC_WRITE : OPC_READ), cmd_addr,
                                    (cmd_write ? cmd_wdata : {WORD_W{1'b0}})};
                    s_d.is_ctl   = 1'b1;
                    s_d.is_rd    = !cmd_write;
                    s_d.ctl_cs_n = 1'b0;
                    s_d.bit_cnt  = '0;
                    s_d.ph       = PH_SETUP;
                end else if (dreq && aud_valid) begin
                    aud_ready    = 1'b1;
                    load         = 1'b1;
                    load_val     = {aud_ordered, {(CTL_BITS-8){1'b0}}};
                    s_d.is_ctl   = 1'b0;
                    s_d.is_rd    = 1'b0;
                    s_d.dat_cs_n = 1'b0;
                    s_d.bit_cnt  = '0;
                    s_d.byte_cnt = BYTE_W'(1);
                    s_d.ph       = PH_SETUP;
                end
            end
            PH_SETUP, PH_LOW: begin
                if (tick) begin
                    s_d.sclk = 1'b1;
                    sample   = 1'b1;
                    s_d.ph   = PH_HIGH;
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    s_d.sclk = 1'b0;
                    if (s_q.bit_cnt == last_bit) begin
                        if (!s_q.is_ctl && (s_q.byte_cnt < BURST_N) && dreq
                            && aud_valid && !cmd_valid) begin
                            aud_ready    = 1'b1;
                            load         = 1'b1;
                            load_val     = {aud_ordered, {(CTL_BITS-8){1'b0}}};
                            s_d.byte_cnt = s_q.byte_cnt + BYTE_W'(1);
                            s_d.bit_cnt  = '0;
                            s_d.ph       = PH_LOW;
                        end else begin
                            s_d.ph = PH_HOLD;
                        end
                    end else begin
                        shift       = 1'b1;
                        s_d.bit_cnt = s_q.bit_cnt + BIT_W'(1);
                        s_d.ph      = PH_LOW;
                    end
                end
            end
            PH_HOLD: begin
                if (tick) begin
                    s_d.ctl_cs_n = 1'b1;
                    s_d.dat_cs_n = 1'b1;
                    if (s_q.is_ctl && s_q.is_rd) begin
                        s_d.rd_valid = 1'b1;
                        s_d.rd_data  = rx_word;
                    end
                    s_d.ph = PH_GAP;
                end
            end
            PH_GAP: begin
                if (tick) begin
                    if (s_q.is_ctl && !s_q.is_rd && (cfg_wait != '0)) begin
                        s_d.wait_cnt = cfg_wait;
                        s_d.ph       = PH_WAIT;
                    end else begin
                        s_d.ph = PH_IDLE;
                    end
                end
            end
            PH_WAIT: begin
                if (s_q.wait_cnt <= WAIT_W'(1)) begin
                    s_d.ph = PH_IDLE;
                end else begin
                    s_d.wait_cnt = s_q.wait_cnt - WAIT_W'(1);
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.ph       <= PH_IDLE;
            s_q.ctl_cs_n <= 1'b1;
            s_q.dat_cs_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk     = s_q.sclk;
    assign ctl_cs_n = s_q.ctl_cs_n;
    assign dat_cs_n = s_q.dat_cs_n;
    assign rd_valid = s_q.rd_valid;
    assign rd_data  = s_q.rd_data;

    assert_cs_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_cs_n || dat_cs_n);

    assert_ctl_start_dreq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_cs_n) |-> $past(dreq));

    assert_dat_start_dreq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dat_cs_n) |-> $past(dreq));

    assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_cs_n && dat_cs_n) |-> !sclk);

    assert_rd_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $rose(ctl_cs_n));

    assert_burst_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.byte_cnt <= BURST_N);

    assert_mosi_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

endmodule

// File: tb/test_codec_spi_host.sv
module test_codec_spi_host;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_half_div = 8'd2;
    logic        cfg_lsb_first = 1'b0;
    logic [15:0] cfg_wait = 16'd0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic [7:0]  cmd_addr = 8'd0;
    logic [15:0] cmd_wdata = 16'd0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        aud_valid = 1'b0;
    logic        aud_ready;
    logic [7:0]  aud_data = 8'd0;
    logic        dreq = 1'b1;
    logic        sclk, mosi, ctl_cs_n, dat_cs_n;
    logic        miso = 1'b0;

    always #5 clk = ~clk;

    codec_spi_host i_codec_spi_host (
        .clk(clk), .rst_n(rst_n), .cfg_half_div(cfg_half_div),
        .cfg_lsb_first(cfg_lsb_first), .cfg_wait(cfg_wait),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .aud_valid(aud_valid), .aud_ready(aud_ready),
        .aud_data(aud_data), .dreq(dreq), .sclk(sclk), .mosi(mosi),
        .miso(miso), .ctl_cs_n(ctl_cs_n), .dat_cs_n(dat_cs_n)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] slave_word(input logic [7:0] a);
        return {a, ~a} ^ 16'h5A3C;
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // expected bench state
    logic [31:0] ctl_exp_q[$];
    int          burst_q[$];
    int          kind_q[$];      // 0 = register frame, 1 = audio frame
    logic [7:0]  aud_mem[0:1023];
    int          aud_n = 0, aud_idx = 0, aud_chk = 0;
    int          cur_h = 2;
    bit          rand_dreq = 1'b0;
    bit          gap_exact = 1'b0;

    // monitor and slave model
    logic        p_sclk = 0, p_ctl = 1, p_dat = 1, p_dreq = 0;
    logic [31:0] ctl_acc;
    logic [7:0]  byte_acc, cur_addr;
    int          ctl_k, dat_k, frame_bytes, since_cs, hrun;
    longint      cyc = 0, rise_cyc = 0;
    bit          after_write = 0;

    always @(negedge clk) begin
        cyc++;
        since_cs++;
        if (rst_n) begin
            chk(ctl_cs_n || dat_cs_n, "R4", "both selects low", 0, 1);
            if ((p_ctl && !ctl_cs_n) || (p_dat && !dat_cs_n)) begin
                chk(p_dreq, "R5", "start without dreq", p_dreq, 1);
                chk(cyc - rise_cyc >= cur_h + 1, "R8", "idle gap", cyc - rise_cyc, cur_h + 1);
                if (after_write) begin
                    if (gap_exact)
                        chk(cyc - rise_cyc == cur_h + cfg_wait + 1, "R9", "write settle gap",
                            cyc - rise_cyc, cur_h + cfg_wait + 1);
                    else
                        chk(cyc - rise_cyc >= cur_h + cfg_wait + 1, "R9", "write settle gap",
                            cyc - rise_cyc, cur_h + cfg_wait + 1);
                end
                since_cs = 0; ctl_k = 0; dat_k = 0; frame_bytes = 0;
                kind_q.push_back(ctl_cs_n ? 1 : 0);
            end
            if (sclk && !p_sclk) begin
                if (ctl_k == 0 && dat_k == 0)
                    chk(since_cs == cur_h, "R8", "select to first edge", since_cs, cur_h);
                if (!ctl_cs_n) begin
                    ctl_acc = {ctl_acc[30:0], mosi};
                    ctl_k++;
                    if (ctl_k == 16) cur_addr = ctl_acc[7:0];
                end
                if (!dat_cs_n) begin
                    byte_acc = {byte_acc[6:0], mosi};
                    dat_k++;
                    if (dat_k % 8 == 0) begin
                        frame_bytes++;
                        if (aud_chk < aud_n)
                            chk((cfg_lsb_first ? rev8(byte_acc) : byte_acc) == aud_mem[aud_chk],
                                "R3", "audio byte", cfg_lsb_first ? rev8(byte_acc) : byte_acc,
                                aud_mem[aud_chk]);
                        else
                            chk(0, "R3", "unexpected audio byte", byte_acc, 0);
                        aud_chk++;
                    end
                end
            end
            if (sclk) hrun++;
            if (!sclk && p_sclk) begin
                chk(hrun == cur_h, "R7", "sclk high time", hrun, cur_h);
                hrun = 0;
            end
            if (!p_ctl && ctl_cs_n) begin
                logic [31:0] e;
                e = (ctl_exp_q.size() > 0) ? ctl_exp_q.pop_front() : 32'hDEAD_BEEF;
                chk(ctl_k == 32, "R1", "register frame length", ctl_k, 32);
                chk(ctl_acc == e, "R1", "register frame bits", ctl_acc, e);
                if (e[31:24] == 8'h03) begin
                    chk(rd_valid == 1'b1, "R2", "read strobe", rd_valid, 1);
                    chk(rd_data == slave_word(e[23:16]), "R2", "read data",
                        rd_data, slave_word(e[23:16]));
                end else begin
                    chk(rd_valid == 1'b0, "R2", "strobe after write", rd_valid, 0);
                end
                after_write = (e[31:24] == 8'h02);
                rise_cyc = cyc;
            end else if (rd_valid) begin
                chk(0, "R2", "stray read strobe", 1, 0);
            end
            if (!p_dat && dat_cs_n) begin
                chk(dat_k % 8 == 0, "R10", "audio frame ends on byte boundary", dat_k % 8, 0);
                chk(frame_bytes <= 32, "R6", "burst length", frame_bytes, 32);
                burst_q.push_back(frame_bytes);
                after_write = 0;
                rise_cyc = cyc;
            end
            // slave response: read word on the last 16 clocks
            if (!ctl_cs_n && ctl_k >= 16 && ctl_k < 32) miso <= slave_word(cur_addr)[31 - ctl_k];
            else miso <= 1'b0;
        end
        p_sclk = sclk; p_ctl = ctl_cs_n; p_dat = dat_cs_n; p_dreq = dreq;
    end

    // audio producer
    initial begin
        forever begin
            @(negedge clk);
            aud_valid = (aud_idx < aud_n);
            aud_data  = aud_mem[aud_idx % 1024];
            #1;
            if (aud_valid && aud_ready) aud_idx++;
        end
    end

    // random dreq
    initial begin
        forever begin
            @(negedge clk);
            if (rand_dreq) dreq = ($urandom % 6) != 0;
        end
    end

    task automatic send_cmd(input bit wr, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        forever begin
            #1;
            if (cmd_ready) begin
                ctl_exp_q.push_back({wr ? 8'h02 : 8'h03, a, wr ? d : 16'h0000});
                @(negedge clk);
                cmd_valid = 1'b0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic add_audio(input int n);
        for (int i = 0; i < n; i++) begin
            aud_mem[aud_n] = 8'($urandom);
            aud_n++;
        end
    endtask

    task automatic drain();
        int quiet;
        quiet = 0;
        while (quiet < 4 * cur_h + 40) begin
            @(negedge clk);
            if (aud_idx == aud_n && ctl_cs_n && dat_cs_n && !cmd_valid) quiet++;
            else quiet = 0;
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(ctl_cs_n == 1 && dat_cs_n == 1, "R11", "selects in reset", {ctl_cs_n, dat_cs_n}, 3);
        chk(sclk == 0 && rd_valid == 0, "R11", "sclk/strobe in reset", {sclk, rd_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6: long stream split into 32/32/6
        cfg_half_div = 8'd1; cur_h = 1; cfg_lsb_first = 0;
        burst_q.delete();
        add_audio(70);
        drain();
        chk(burst_q.size() == 3, "R6", "burst count", burst_q.size(), 3);
        if (burst_q.size() == 3) begin
            chk(burst_q[0] == 32 && burst_q[1] == 32, "R6", "full bursts", burst_q[0], 32);
            chk(burst_q[2] == 6, "R6", "tail burst", burst_q[2], 6);
        end
        chk(aud_chk == aud_n, "R3", "bytes delivered", aud_chk, aud_n);

        // R5: dreq low blocks a pending command
        dreq = 1'b0;
        fork
            send_cmd(1'b0, 8'h4B, 16'h0);
            begin
                repeat (60) @(negedge clk);
                chk(ctl_cs_n == 1'b1 && cmd_valid == 1'b1, "R5", "held while dreq low",
                    ctl_cs_n, 1);
                dreq = 1'b1;
            end
        join
        drain();

        // R9: back-to-back writes, exact settle gap
        cfg_half_div = 8'd3; cur_h = 3; cfg_wait = 16'd7; gap_exact = 1;
        fork
            begin
                send_cmd(1'b1, 8'h0B, 16'hA55A);
                send_cmd(1'b1, 8'h03, 16'h1234);
            end
        join
        drain();
        gap_exact = 0;

        // R10: command during an audio burst
        cfg_half_div = 8'd2; cur_h = 2; cfg_wait = 0; cfg_lsb_first = 1;
        kind_q.delete();
        add_audio(20);
        while (aud_chk < aud_n - 17) @(negedge clk);
        send_cmd(1'b0, 8'h21, 16'h0);
        drain();
        chk(kind_q.size() >= 3, "R10", "frame count", kind_q.size(), 3);
        if (kind_q.size() >= 3)
            chk(kind_q[0] == 1 && kind_q[1] == 0 && kind_q[2] == 1, "R10", "frame order",
                {kind_q[0][3:0], kind_q[1][3:0], kind_q[2][3:0]}, 12'h101);

        // random phases
        for (int ph = 0; ph < 4; ph++) begin
            cfg_half_div = 8'(ph);
            cur_h = (ph == 0) ? 1 : ph;
            cfg_lsb_first = ph[0];
            cfg_wait = 16'($urandom % 12);
            rand_dreq = 1'b1;
            add_audio(40);
            for (int i = 0; i < 12; i++) begin
                repeat ($urandom % 30) @(negedge clk);
                send_cmd(1'($urandom), 8'($urandom), 16'($urandom));
            end
            rand_dreq = 1'b0;
            dreq = 1'b1;
            drain();
            chk(ctl_exp_q.size() == 0, "R1", "all register frames seen", ctl_exp_q.size(), 0);
            chk(aud_chk == aud_n, "R3", "all audio bytes seen", aud_chk, aud_n);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule